// File: doc/BRIEF.md
# TLB control and replacement register

This block is the control register for a four-way set-associative translation buffer. It holds four control bits: the translation enable, the index-mode select, the single-address-space select and a self-clearing flush command. It also keeps a two-bit way counter that tells the refill logic which way of a set to replace next. Software reaches the register through a plain write strobe with write data and a combinational read bus.

On every MMU exception, the exception logic presents a one-cycle event to the block. The event carries the exception kind, the valid bits of the four ways in the indexed set, and the way that faulted. The block uses these to update the way counter.

The block also forms the five-bit set index from virtual-address bits 16:12. In hashed index mode, it XORs those bits with the low five bits of the current address-space identifier. A write with the flush bit set produces a single-cycle pulse that the TLB storage uses to clear every valid bit.

Top module: `tlb_ctrl_reg`

## Requirements
- R1: After reset, every register bit reads 0, `flush_pulse` is low, and `xlat_en` and `single_vm` are low.
- R2: A write stores bit 0 (translation enable, also driven on `xlat_en`), bit 1 (index mode) and bit 8 (single address space, also driven on `single_vm`). All bits other than 0, 1, 4, 5 and 8 read as 0 whatever was written.
- R3: Bit 2 always reads 0. A write with bit 2 set raises `flush_pulse` for exactly the one cycle that follows the write edge.
- R4: With index mode 0, `tlb_index` equals `vaddr[16:12]`.
- R5: With index mode 1, `tlb_index` equals `vaddr[16:12]` XOR `asid[4:0]`.
- R6: An event of type miss (`exc_type`=1) with all four `exc_way_valid` bits set increments the way counter (bits 5:4) by one, modulo 4.
- R7: A miss event with at least one `exc_way_valid` bit clear loads the counter with the lowest-numbered clear bit.
- R8: An event of type other (`exc_type`=2) loads the counter with `exc_way`.
- R9: A write loads the counter from `wdata[5:4]`. When a write and a miss or other event fall in the same cycle, the event sets the counter and the write's other bits still take effect.
- R10: The counter does not change when `exc_valid` is low, or when `exc_type` is 0 or 3, unless a write occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data |
| exc_valid | input | 1 | One-cycle MMU exception event strobe |
| exc_type | input | 2 | Event kind: 0 none, 1 miss, 2 other, 3 none |
| exc_way_valid | input | 4 | Valid bits of the four ways in the indexed set |
| exc_way | input | 2 | Way that caused a non-miss exception |
| vaddr | input | 32 | Virtual address being translated |
| asid | input | 8 | Current address-space identifier |
| tlb_index | output | 5 | Set index for the TLB |
| flush_pulse | output | 1 | One-cycle request to clear all TLB valid bits |
| xlat_en | output | 1 | Address translation enabled |
| single_vm | output | 1 | Single address-space mode |

## Verification
Register contents and the way counter change at the rising edge that samples a write or an event, so `rdata` shows the change one cycle after the stimulus. `flush_pulse` is high during the cycle that follows the write. `tlb_index` is combinational and is due in the same cycle as `vaddr`, `asid` or a change of the index-mode bit. The bench applies inputs shortly after each falling edge and advances a behavioural model at each rising edge. It compares every output with the model at the next falling edge, so each result is checked exactly in the cycle it is due.

// File: rtl/tlb_ctrl_reg.sv
module tlb_ctrl_reg #(
  parameter int VA_W    = 32,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = 5,
  parameter int IDX_LSB = 12,
  parameter int WAYS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              exc_valid,
  input  logic [1:0]        exc_type,
  input  logic [WAYS-1:0]   exc_way_valid,
  input  logic [1:0]        exc_way,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [ASID_W-1:0] asid,
  output logic [IDX_W-1:0]  tlb_index,
  output logic              flush_pulse,
  output logic              xlat_en,
  output logic              single_vm
);
  localparam int WAY_W = $clog2(WAYS);
  localparam logic [1:0] EXC_MISS  = 2'd1;
  localparam logic [1:0] EXC_OTHER = 2'd2;

  logic             xlat_q, idxm_q, svm_q, flush_q;
  logic [WAY_W-1:0] rc_q, rc_nxt, free_way;
  logic             hw_miss, hw_other, all_valid;

  assign hw_miss   = exc_valid && (exc_type == EXC_MISS);
  assign hw_other  = exc_valid && (exc_type == EXC_OTHER);
  assign all_valid = &exc_way_valid;

  always_comb begin
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!exc_way_valid[i]) free_way = WAY_W'(i);
  end

  always_comb begin
    if (hw_miss)       rc_nxt = all_valid ? rc_q + WAY_W'(1) : free_way;
    else if (hw_other) rc_nxt = WAY_W'(exc_way);
    else if (wr_en)    rc_nxt = wdata[4 +: WAY_W];
    else               rc_nxt = rc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlat_q  <= 1'b0;
      idxm_q  <= 1'b0;
      svm_q   <= 1'b0;
      flush_q <= 1'b0;
      rc_q    <= '0;
    end else begin
      flush_q <= wr_en & wdata[2];
      rc_q    <= rc_nxt;
      if (wr_en) begin
        xlat_q <= wdata[0];
        idxm_q <= wdata[1];
        svm_q  <= wdata[8];
      end
    end
  end

  always_comb begin
    rdata = '0;
    rdata[0] = xlat_q;
    rdata[1] = idxm_q;
    rdata[4 +: WAY_W] = rc_q;
    rdata[8] = svm_q;
  end

  assign tlb_index   = vaddr[IDX_LSB +: IDX_W] ^ (idxm_q ? asid[IDX_W-1:0] : '0);
  assign flush_pulse = flush_q;
  assign xlat_en     = xlat_q;
  assign single_vm   = svm_q;

  logic unused_bits;
  assign unused_bits = ^{wdata[31:9], wdata[7:6], wdata[3], vaddr, asid};

  // R3
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(wr_en && wdata[2]));
  // R3
  flush_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[2]) |=> flush_pulse);
  // R6
  miss_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_miss && all_valid) |=> rdata[5:4] == $past(rdata[5:4]) + 2'd1);
  // R7
  miss_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_miss && !all_valid) |=> ((($past(exc_way_valid) >> rdata[5:4]) & 4'd1) == 4'd0));
  // R8
  other_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_other |=> rdata[5:4] == $past(exc_way));
  // R10
  rc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_miss && !hw_other && !wr_en) |=> $stable(rdata[5:4]));
endmodule

// File: tb/tlb_ctrl_reg_bench.sv
module tlb_ctrl_reg_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic exc_valid = 1'b0;
  logic [1:0] exc_type = '0, exc_way = '0;
  logic [3:0] exc_way_valid = '0;
  logic [31:0] vaddr = '0;
  logic [7:0] asid = '0;
  logic [4:0] tlb_index;
  logic flush_pulse, xlat_en, single_vm;

  int total = 0, bad = 0;
  bit chk_on = 0, done = 0;
  string cur_req = "R1";
  int m_x = 0, m_i = 0, m_s = 0, m_rc = 0, m_fl = 0;

  always #5 clk = ~clk;

  tlb_ctrl_reg u_tlb_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .exc_valid(exc_valid), .exc_type(exc_type), .exc_way_valid(exc_way_valid),
    .exc_way(exc_way), .vaddr(vaddr), .asid(asid), .tlb_index(tlb_index),
    .flush_pulse(flush_pulse), .xlat_en(xlat_en), .single_vm(single_vm));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_x = 0; m_i = 0; m_s = 0; m_rc = 0; m_fl = 0;
    end else begin
      int old_rc;
      old_rc = m_rc;
      m_fl = (wr_en && wdata[2]) ? 1 : 0;
      if (wr_en) begin
        m_x = wdata[0]; m_i = wdata[1]; m_s = wdata[8]; m_rc = wdata[5:4];
      end
      if (exc_valid && exc_type == 2'd1) begin
        if (exc_way_valid == 4'hF) m_rc = (old_rc + 1) % 4;
        else begin
          int pick;
          pick = -1;
          for (int w = 0; w < 4; w++)
            if (pick < 0 && !exc_way_valid[w]) pick = w;
          m_rc = pick;
        end
      end else if (exc_valid && exc_type == 2'd2) m_rc = exc_way;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    int e_idx;
    e_idx = vaddr[16:12];
    if (m_i != 0) e_idx = e_idx ^ asid[4:0];
    chk(cur_req, "rdata", rdata, (m_s << 8) | (m_rc << 4) | (m_i << 1) | m_x);
    chk("R3", "flush_pulse", flush_pulse, m_fl);
    chk("R2", "xlat_en", xlat_en, m_x);
    chk("R2", "single_vm", single_vm, m_s);
    chk(m_i != 0 ? "R5" : "R4", "tlb_index", tlb_index, e_idx);
  end

  task automatic cyc(bit we, logic [31:0] wd, bit ev, logic [1:0] et,
                     logic [3:0] wv, logic [1:0] ew);
    @(negedge clk);
    #1;
    wr_en = we; wdata = wd; exc_valid = ev; exc_type = et;
    exc_way_valid = wv; exc_way = ew;
    vaddr = $urandom; asid = 8'($urandom);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, '0, 0, 2'd0, 4'h0, 2'd0);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset rdata", rdata, 0);
    chk("R1", "reset flush", flush_pulse, 0);
    chk("R1", "reset xlat_en", xlat_en, 0);
    chk("R1", "reset single_vm", single_vm, 0);
    #1 rst_n = 1'b1;
    chk_on = 1;
    idle(2);
    cur_req = "R2";
    cyc(1, 32'h0000_0103, 0, 2'd0, 4'h0, 2'd0);
    idle(1);
    cyc(1, 32'hFFFF_FECB, 0, 2'd0, 4'h0, 2'd0);
    idle(1);
    cyc(1, 32'h0000_0000, 0, 2'd0, 4'h0, 2'd0);
    idle(1);
    cur_req = "R3";
    cyc(1, 32'h0000_0004, 0, 2'd0, 4'h0, 2'd0);
    idle(2);
    cyc(1, 32'h0000_0005, 0, 2'd0, 4'h0, 2'd0);
    cyc(1, 32'h0000_0004, 0, 2'd0, 4'h0, 2'd0);
    idle(2);
    cur_req = "R4";
    idle(20);
    cur_req = "R5";
    cyc(1, 32'h0000_0002, 0, 2'd0, 4'h0, 2'd0);
    idle(20);
    cur_req = "R6";
    cyc(1, 32'h0000_0030, 0, 2'd0, 4'h0, 2'd0);
    for (int k = 0; k < 6; k++) cyc(0, '0, 1, 2'd1, 4'hF, 2'd0);
    idle(1);
    cur_req = "R7";
    for (int v = 0; v < 15; v++) begin
      cyc(1, 32'h0000_0030, 0, 2'd0, 4'h0, 2'd0);
      cyc(0, '0, 1, 2'd1, 4'(v), 2'd0);
    end
    idle(1);
    cur_req = "R8";
    for (int w = 3; w >= 0; w--) cyc(0, '0, 1, 2'd2, 4'hF, 2'(w));
    idle(1);
    cur_req = "R9";
    cyc(1, 32'h0000_0120, 0, 2'd0, 4'h0, 2'd0);
    cyc(1, 32'h0000_0021, 1, 2'd2, 4'h0, 2'd3);
    cyc(1, 32'h0000_0010, 1, 2'd1, 4'hF, 2'd0);
    cyc(1, 32'h0000_0030, 1, 2'd1, 4'hB, 2'd0);
    cyc(1, 32'h0000_0010, 0, 2'd0, 4'h0, 2'd0);
    idle(1);
    cur_req = "R10";
    cyc(0, '0, 0, 2'd1, 4'hF, 2'd3);
    cyc(0, '0, 0, 2'd2, 4'h0, 2'd2);
    cyc(0, '0, 1, 2'd0, 4'h0, 2'd2);
    cyc(0, '0, 1, 2'd3, 4'h0, 2'd3);
    idle(2);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule